// File: doc/BRIEF.md
# Bridge Interrupt Status Register

This block holds the interrupt status word that a bus bridge presents on its PCI-side control register space. Three sticky error flags record failures seen by the bridge datapath: a failed write toward PCI, a failed read from PCI (either one aborted or out of retries), and non-prefetchable read data dropped because the PCI requester did not retry before the discard timer ran out. Each flag stays set until a host clears it by writing a 1. The clear can come from the PCI-side register port, or from the local memory-mapped side through the matching bit of that side's own interrupt status register.

Next to the sticky flags, the word carries live read-only copies of the local interrupt input and of two PCI configuration status bits: parity error reported and target abort signaled. Build parameters choose which sticky flags exist. The two transfer-failure flags need master/target peripheral or host-bridge mode. The discard flag needs the non-prefetchable local master port. The block drives an active-low interrupt request whenever an enabled source is active.

Top module: `brg_irq_status`

## Requirements
- R1: The word is decoded at byte offset 0x40 (parameter `REG_OFFSET`). A read at any other address returns 0, and a write at any other address clears nothing.
- R2: Bit 0 becomes 1 on the clock edge after `ev_wr_fail` is sampled high. It stays 1 until it is cleared.
- R3: Bit 1 becomes 1 on the clock edge after `ev_rd_fail` is sampled high. It stays 1 until it is cleared.
- R4: Bit 2 becomes 1 on the clock edge after `ev_np_discard` is sampled high. It stays 1 until it is cleared.
- R5: A PCI-side write at offset 0x40 with a 1 in data bit 0, 1 or 2 clears that flag on the same edge. A 0 in that data bit leaves the flag unchanged.
- R6: A local-side clear strobe with a 1 in `loc_clr_data` bit 0, 1 or 2 clears the flag at the same bit position. If both ports clear the same bit in one cycle, the bit is cleared once.
- R7: If a set event and a clear reach the same flag in the same cycle, the flag ends up 1.
- R8: Bits 0 and 1 exist only when `HAS_MASTER` is 1, and bit 2 exists only when `HAS_NP_PORT` is 1. An absent bit always reads 0 and never drives the interrupt.
- R9: Bits 6:3 and 31:10 always read 0. Writing 1s to them, or to bits 7 to 9, changes nothing.
- R10: Bit 7 always shows the present level of `loc_irq_in`.
- R11: Bit 8 shows `cfg_status[8]` and bit 9 shows `cfg_status[11]`. A write to this word cannot change either bit.
- R12: `irq_n` is 0 exactly when one of these holds: bit 0 and `irq_en[0]`, bit 1 and `irq_en[1]`, bit 2 and `irq_en[2]`, or bit 7 and `irq_en[3]`.
- R13: A synchronous reset clears all sticky flags, even when events are active during the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pci_addr | input | ADDR_W | PCI-side register byte address, used for both reads and writes |
| pci_wr_en | input | 1 | PCI-side write strobe |
| pci_wdata | input | 32 | PCI-side write data; a 1 in bits 2:0 clears the matching flag |
| pci_rdata | output | 32 | Status word when `pci_addr` hits, otherwise 0 |
| loc_clr_en | input | 1 | Write strobe from the local-side interrupt status register |
| loc_clr_data | input | 3 | Write-1-to-clear data from the local side, one bit per flag |
| ev_wr_fail | input | 1 | Pulse: a write toward PCI failed |
| ev_rd_fail | input | 1 | Pulse: a read from PCI failed |
| ev_np_discard | input | 1 | Pulse: non-prefetchable read data was discarded |
| loc_irq_in | input | 1 | Local-side interrupt level |
| cfg_status | input | 16 | PCI configuration status register value |
| irq_en | input | 4 | Interrupt enables for bits 0, 1, 2 and bit 7 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench steps through every combination of set events, PCI-side clears and local-side clears, starting from a different flag state each time. A design that lets the clear win over a set would lose a 1 in R7 cases. A design that ORs the two clear sources incorrectly, or ignores one of them, would leave a flag set. A second copy of the block, built with every optional flag absent, runs the same stimulus: any event that leaks into a missing bit shows up as a nonzero low bit or as a spurious interrupt. Writes that put 1s in reserved and mirror positions, or that target a neighbouring address, catch a decoder that clears too widely. The interrupt output is checked for all sixteen enable masks against every flag pattern and both local interrupt levels.

// File: rtl/brg_irq_pkg.sv
`timescale 1ns/1ps
package brg_irq_pkg;
    localparam int DATA_W    = 32;
    localparam int ERR_N     = 3;
    localparam int CFG_W     = 16;
    localparam int IRQ_SRC_N = ERR_N + 1;
    localparam int POS_LIRQ  = 7;
    localparam int POS_PERR  = 8;
    localparam int POS_TABT  = 9;
    localparam int CFG_PERR  = 8;
    localparam int CFG_TABT  = 11;

    typedef struct packed {
        logic discard;
        logic rd_fail;
        logic wr_fail;
    } err_vec_t;

    typedef struct packed {
        logic tabort;
        logic perr;
        logic local_irq;
    } mirror_t;

    function automatic logic [ERR_N-1:0] present_mask(input bit has_master, input bit has_np);
        return {has_np, has_master, has_master};
    endfunction

    function automatic logic [DATA_W-1:0] compose(input logic [ERR_N-1:0] flags, input mirror_t m);
        logic [DATA_W-1:0] w;
        w              = '0;
        w[ERR_N-1:0]   = flags;
        w[POS_LIRQ]    = m.local_irq;
        w[POS_PERR]    = m.perr;
        w[POS_TABT]    = m.tabort;
        return w;
    endfunction
endpackage

// File: rtl/brg_sticky_bit.sv
`timescale 1ns/1ps
module brg_sticky_bit #(
    parameter bit PRESENT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    generate
        if (PRESENT) begin : g_flop
            logic q;
            always_ff @(posedge clk) begin
                if (rst)        q <= 1'b0;
                else if (set_i) q <= 1'b1;   // a set beats a clear in the same cycle
                else if (clr_i) q <= 1'b0;
            end
            assign q_o = q;
        end else begin : g_absent
            logic unused_in;
            assign unused_in = ^{clk, rst, set_i, clr_i};
            assign q_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/brg_irq_combine.sv
`timescale 1ns/1ps
module brg_irq_combine #(
    parameter int N = 4
) (
    input  logic [N-1:0] src,
    input  logic [N-1:0] en,
    output logic         irq_n
);
    assign irq_n = ~(|(src & en));
endmodule

// File: rtl/brg_irq_status.sv
`timescale 1ns/1ps
module brg_irq_status
    import brg_irq_pkg::*;
#(
    parameter bit                HAS_MASTER  = 1'b1,
    parameter bit                HAS_NP_PORT = 1'b1,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET  = 'h40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    pci_addr,
    input  logic                 pci_wr_en,
    input  logic [DATA_W-1:0]    pci_wdata,
    output logic [DATA_W-1:0]    pci_rdata,
    input  logic                 loc_clr_en,
    input  logic [ERR_N-1:0]     loc_clr_data,
    input  logic                 ev_wr_fail,
    input  logic                 ev_rd_fail,
    input  logic                 ev_np_discard,
    input  logic                 loc_irq_in,
    input  logic [CFG_W-1:0]     cfg_status,
    input  logic [IRQ_SRC_N-1:0] irq_en,
    output logic                 irq_n
);
    localparam logic [ERR_N-1:0] PRESENT = present_mask(HAS_MASTER, HAS_NP_PORT);

    err_vec_t         ev;
    logic [ERR_N-1:0] ev_bits;
    logic             hit;
    logic [ERR_N-1:0] clr_pci, clr_loc, clr_any;
    logic [ERR_N-1:0] flag_q;
    mirror_t          mir;

    assign ev      = '{discard: ev_np_discard, rd_fail: ev_rd_fail, wr_fail: ev_wr_fail};
    assign ev_bits = ev;
    assign hit     = (pci_addr == REG_OFFSET);
    assign clr_pci = {ERR_N{pci_wr_en & hit}} & pci_wdata[ERR_N-1:0];
    assign clr_loc = {ERR_N{loc_clr_en}} & loc_clr_data;
    assign clr_any = clr_pci | clr_loc;

    generate
        for (genvar i = 0; i < ERR_N; i++) begin : g_flag
            brg_sticky_bit #(.PRESENT(PRESENT[i])) u_bit (
                .clk   (clk),
                .rst   (rst),
                .set_i (ev_bits[i]),
                .clr_i (clr_any[i]),
                .q_o   (flag_q[i])
            );
        end
    endgenerate

    assign mir = '{tabort: cfg_status[CFG_TABT], perr: cfg_status[CFG_PERR], local_irq: loc_irq_in};
    assign pci_rdata = hit ? compose(flag_q, mir) : '0;

    brg_irq_combine #(.N(IRQ_SRC_N)) u_irq (
        .src   ({loc_irq_in, flag_q}),
        .en    (irq_en),
        .irq_n (irq_n)
    );

    logic unused_bits;
    assign unused_bits = ^{pci_wdata[DATA_W-1:ERR_N], cfg_status[CFG_W-1:CFG_TABT+1],
                           cfg_status[CFG_TABT-1:CFG_PERR+1], cfg_status[CFG_PERR-1:0]};
endmodule

// File: rtl/brg_irq_status_chk.sv
`timescale 1ns/1ps
module brg_irq_status_chk
    import brg_irq_pkg::*;
#(
    parameter bit                HAS_MASTER  = 1'b1,
    parameter bit                HAS_NP_PORT = 1'b1,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET  = 'h40
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    pci_addr,
    input logic                 pci_wr_en,
    input logic [DATA_W-1:0]    pci_wdata,
    input logic [DATA_W-1:0]    pci_rdata,
    input logic                 loc_clr_en,
    input logic [ERR_N-1:0]     loc_clr_data,
    input logic                 ev_wr_fail,
    input logic                 ev_rd_fail,
    input logic                 ev_np_discard,
    input logic                 loc_irq_in,
    input logic [CFG_W-1:0]     cfg_status,
    input logic [IRQ_SRC_N-1:0] irq_en,
    input logic                 irq_n,
    input logic [ERR_N-1:0]     flag_q
);
    localparam logic [ERR_N-1:0] PRES = {HAS_NP_PORT, HAS_MASTER, HAS_MASTER};

    logic             at_reg;
    logic [ERR_N-1:0] evs, pclr, lclr;
    assign at_reg = (pci_addr == REG_OFFSET);
    assign evs    = {ev_np_discard, ev_rd_fail, ev_wr_fail};
    assign pclr   = (pci_wr_en && at_reg) ? pci_wdata[ERR_N-1:0] : '0;
    assign lclr   = loc_clr_en ? loc_clr_data : '0;

    generate
        for (genvar i = 0; i < ERR_N; i++) begin : g_bit
            if (PRES[i]) begin : g_pres
                // R2 R3 R4 R7: an event always leaves the flag set
                assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
                    evs[i] |=> flag_q[i]);
                assert_pci_clear_R5: assert property (@(posedge clk) disable iff (rst)
                    (!evs[i] && pclr[i]) |=> !flag_q[i]);
                assert_loc_clear_R6: assert property (@(posedge clk) disable iff (rst)
                    (!evs[i] && lclr[i]) |=> !flag_q[i]);
                assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (rst)
                    (!evs[i] && !pclr[i] && !lclr[i]) |=> $stable(flag_q[i]));
            end else begin : g_abs
                assert_absent_zero_R8: assert property (@(posedge clk) disable iff (rst)
                    !flag_q[i]);
            end
        end
    endgenerate

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
        at_reg |-> (pci_rdata[6:3] == 4'b0 && pci_rdata[DATA_W-1:POS_TABT+1] == '0));
    assert_miss_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !at_reg |-> (pci_rdata == '0));
    assert_live_irq_R10: assert property (@(posedge clk) disable iff (rst)
        at_reg |-> (pci_rdata[POS_LIRQ] == loc_irq_in));
    assert_cfg_mirror_R11: assert property (@(posedge clk) disable iff (rst)
        at_reg |-> (pci_rdata[POS_PERR] == cfg_status[CFG_PERR] &&
                    pci_rdata[POS_TABT] == cfg_status[CFG_TABT]));
    assert_irq_active_R12: assert property (@(posedge clk) disable iff (rst)
        (((flag_q & irq_en[ERR_N-1:0]) != '0) || (loc_irq_in && irq_en[ERR_N])) |-> !irq_n);
    assert_irq_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (((flag_q & irq_en[ERR_N-1:0]) == '0) && !(loc_irq_in && irq_en[ERR_N])) |-> irq_n);
    assert_reset_clear_R13: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flag_q == '0));

    logic unused_chk;
    assign unused_chk = ^{pci_wdata[DATA_W-1:ERR_N], cfg_status};
endmodule

bind brg_irq_status brg_irq_status_chk #(
    .HAS_MASTER(HAS_MASTER), .HAS_NP_PORT(HAS_NP_PORT),
    .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
) u_chk (
    .clk(clk), .rst(rst), .pci_addr(pci_addr), .pci_wr_en(pci_wr_en),
    .pci_wdata(pci_wdata), .pci_rdata(pci_rdata), .loc_clr_en(loc_clr_en),
    .loc_clr_data(loc_clr_data), .ev_wr_fail(ev_wr_fail), .ev_rd_fail(ev_rd_fail),
    .ev_np_discard(ev_np_discard), .loc_irq_in(loc_irq_in), .cfg_status(cfg_status),
    .irq_en(irq_en), .irq_n(irq_n), .flag_q(flag_q)
);

// File: tb/brg_irq_status_test.sv
`timescale 1ns/1ps
module brg_irq_status_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  pci_addr;
    logic        pci_wr_en;
    logic [31:0] pci_wdata;
    logic [31:0] rdata, rdata_min;
    logic        loc_clr_en;
    logic [2:0]  loc_clr_data;
    logic        ev_wr_fail, ev_rd_fail, ev_np_discard;
    logic        loc_irq_in;
    logic [15:0] cfg_status;
    logic [3:0]  irq_en;
    logic        irq_n, irq_n_min;

    int checks = 0;
    int fails  = 0;
    logic [2:0] model;   // flags of the full build; the reduced build holds none

    always #10 clk = ~clk;   // 50 MHz

    brg_irq_status uut (
        .clk(clk), .rst(rst), .pci_addr(pci_addr), .pci_wr_en(pci_wr_en),
        .pci_wdata(pci_wdata), .pci_rdata(rdata), .loc_clr_en(loc_clr_en),
        .loc_clr_data(loc_clr_data), .ev_wr_fail(ev_wr_fail), .ev_rd_fail(ev_rd_fail),
        .ev_np_discard(ev_np_discard), .loc_irq_in(loc_irq_in), .cfg_status(cfg_status),
        .irq_en(irq_en), .irq_n(irq_n));

    brg_irq_status #(.HAS_MASTER(1'b0), .HAS_NP_PORT(1'b0)) uut_min (
        .clk(clk), .rst(rst), .pci_addr(pci_addr), .pci_wr_en(pci_wr_en),
        .pci_wdata(pci_wdata), .pci_rdata(rdata_min), .loc_clr_en(loc_clr_en),
        .loc_clr_data(loc_clr_data), .ev_wr_fail(ev_wr_fail), .ev_rd_fail(ev_rd_fail),
        .ev_np_discard(ev_np_discard), .loc_irq_in(loc_irq_in), .cfg_status(cfg_status),
        .irq_en(irq_en), .irq_n(irq_n_min));

    function automatic logic [31:0] expect_word(input logic [2:0] f);
        return {22'b0, cfg_status[11], cfg_status[8], loc_irq_in, 4'b0, f};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [2:0] ev, input logic [2:0] pc, input logic [2:0] lc);
        @(negedge clk);
        {ev_np_discard, ev_rd_fail, ev_wr_fail} = ev;
        pci_addr     = 8'h40;
        pci_wr_en    = (pc != 3'b0);
        pci_wdata    = {29'h1FFFFFFF, pc};
        loc_clr_en   = (lc != 3'b0);
        loc_clr_data = lc;
        @(posedge clk);
        #2;
        {ev_np_discard, ev_rd_fail, ev_wr_fail} = 3'b0;
        pci_wr_en    = 1'b0;
        pci_wdata    = '0;
        loc_clr_en   = 1'b0;
        loc_clr_data = '0;
        model = (model & ~(pc | lc)) | ev;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; pci_addr = 8'h40; pci_wr_en = 0; pci_wdata = '0;
        loc_clr_en = 0; loc_clr_data = '0; loc_irq_in = 0; cfg_status = '0; irq_en = '0;
        {ev_np_discard, ev_rd_fail, ev_wr_fail} = 3'b111;   // events held during reset
        model = 3'b0;
        repeat (3) @(posedge clk);
        #2;
        chk("R13 reset", rdata, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        {ev_np_discard, ev_rd_fail, ev_wr_fail} = 3'b0;
        @(posedge clk); #2;

        // Directed single-event checks
        apply(3'b001, 0, 0); chk("R2 write fail sets bit0", rdata, expect_word(3'b001));
        apply(3'b000, 0, 0); chk("R2 bit0 sticky", rdata, expect_word(3'b001));
        apply(3'b010, 0, 0); chk("R3 read fail sets bit1", rdata, expect_word(3'b011));
        apply(3'b100, 0, 0); chk("R4 discard sets bit2", rdata, expect_word(3'b111));

        // R1: writes at a neighbouring address clear nothing; reads there return 0
        @(negedge clk);
        pci_addr = 8'h44; pci_wr_en = 1; pci_wdata = '1;
        @(posedge clk); #2;
        pci_wr_en = 0; pci_wdata = '0;
        chk("R1 miss read zero", rdata, 32'h0);
        pci_addr = 8'h40; #1;
        chk("R1 miss write ignored", rdata, expect_word(model));

        // R10 / R11: live mirrors, unaffected by writes of 1s
        loc_irq_in = 1; cfg_status = 16'h0900; #1;
        chk("R10 live local irq", rdata, expect_word(model));
        apply(3'b000, 3'b111, 0);
        chk("R11 mirrors survive write", rdata, {22'b0, 2'b11, 1'b1, 4'b0, 3'b000});
        chk("R9 reserved read zero", rdata & 32'hFFFFFC78, 32'h0);
        loc_irq_in = 0; cfg_status = 16'h0100; #1;
        chk("R11 perr only", rdata, 32'h0000_0100);

        // Sweep of every event / PCI clear / local clear combination
        for (int e = 0; e < 8; e++) begin
            for (int p = 0; p < 8; p++) begin
                for (int l = 0; l < 8; l++) begin
                    string tag;
                    apply(3'b000, 3'b111, 0);
                    apply(3'((e + p + l + 3) % 8), 0, 0);
                    loc_irq_in = e[0] ^ l[1];
                    cfg_status = 16'((p * 613 + l * 97 + e * 29) & 16'hFFFF);
                    apply(3'(e), 3'(p), 3'(l));
                    if ((e & (p | l)) != 0) tag = "R7 set beats clear";
                    else if ((p & l) != 0) tag = "R6 dual clear";
                    else if (l != 0) tag = "R6 local clear";
                    else if (p != 0) tag = "R5 pci clear";
                    else tag = "R2 hold";
                    chk(tag, rdata, expect_word(model));
                    chk("R8 absent bits", rdata_min, expect_word(3'b000));
                end
            end
        end

        // R12: interrupt output for every flag pattern, local level and enable mask
        for (int f = 0; f < 8; f++) begin
            apply(3'b000, 3'b111, 0);
            apply(3'(f), 0, 0);
            for (int li = 0; li < 2; li++) begin
                for (int en = 0; en < 16; en++) begin
                    logic exp_n, exp_min_n;
                    loc_irq_in = li[0]; irq_en = 4'(en); #1;
                    exp_n     = !(((3'(f) & irq_en[2:0]) != 0) || (li[0] && irq_en[3]));
                    exp_min_n = !(li[0] && irq_en[3]);
                    chk("R12 irq_n", {31'b0, irq_n}, {31'b0, exp_n});
                    chk("R8 irq_n absent", {31'b0, irq_n_min}, {31'b0, exp_min_n});
                end
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule